// File: doc/BRIEF.md
# Character Tile Text Renderer

This block turns the pixel coordinate coming from a 640x480 raster timing source into one text pixel and a three-bit colour. The screen is divided into cells 8 pixels wide and 16 lines tall, giving 80 columns and 30 rows of characters. The block reports the column and row of the cell under the current coordinate. In the same cycle, the caller answers with the 7-bit character code for that cell.

The code and the line within the cell together address a built-in glyph memory. The memory returns an 8-bit row, and the column within the cell picks one bit of that row, with the leftmost pixel taken from the most significant bit. The selected bit is gated by the caller's foreground colour and by the video-active flag. The coordinate stage, the memory read and the bit stage are each registered, so the result appears a fixed three clocks after its inputs. The colour and video-active inputs travel through the same pipeline, so they stay aligned with the pixel.

Top module: `text_tile_renderer`

## Requirements
- R1: The glyph word for character code 0x00, and for every code not named in R2, R3 or R4, is 0x00 on every row.
- R2: Code 0x7F is a solid block: its glyph word is 0xFF on all 16 rows.
- R3: Code 0x01 is a test pattern: on row r (0..15) its glyph word is r in the upper four bits and the bitwise inverse of r in the lower four bits.
- R4: Codes 0x30 to 0x39 draw the digits 0 to 9 as seven segments. The segment masks, bit 0 = top through bit 6 = middle in the order top, upper right, lower right, bottom, lower left, upper left, middle, are 3F,06,5B,4F,66,6D,7D,07,7F,6F. Top, middle and bottom light pixel columns 1 to 6 on rows 2, 7 and 12. Upper left and upper right light column 1 and column 6 on rows 2 to 7. Lower left and lower right light column 1 and column 6 on rows 7 to 12. All other pixels are dark.
- R5: The glyph row is selected by the code joined above Y bits 3..0. The pixel at column c (X bits 2..0, 0 = leftmost) is glyph word bit 7-c, so the image is not mirrored.
- R6: pix_bit and rgb reflect the pix_x, pix_y, char_code, video_on and fg_color values sampled three rising edges earlier.
- R7: While the delayed video_on is high, each rgb bit equals pix_bit ANDed with the matching bit of the delayed fg_color. A dark pixel gives black.
- R8: While the delayed video_on is low, rgb is 0, and pix_bit still shows the glyph pixel.
- R9: cell_col equals pix_x bits 9..3 and cell_row equals pix_y bits 8..4, combinationally in the same cycle.
- R10: An active-low asynchronous reset clears pix_bit and rgb at once. For the first three edges after release, the outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_x | input | 10 | Current pixel column, 0..639 |
| pix_y | input | 9 | Current pixel line, 0..479 |
| video_on | input | 1 | High inside the visible area |
| char_code | input | 7 | Character code for the cell at cell_col/cell_row |
| fg_color | input | 3 | Foreground colour for the current cell |
| cell_col | output | 7 | Character column of the current coordinate |
| cell_row | output | 5 | Character row of the current coordinate |
| pix_bit | output | 1 | Glyph pixel, three clocks late |
| rgb | output | 3 | Colour output, three clocks late |

## Verification
The assertions assume that char_code, fg_color and video_on are sampled on the same edge as the coordinate they belong to. They also assume the three-cycle alignment holds only after three edges out of reset, which is why a counter from reset gates them. The stimulus changes all inputs together, half a period away from the active edge. The char_code it supplies is a function of cell_col and cell_row, as the caller's lookup would be. The stimulus covers every line of a cell row across many cells, a full bottom line, random coordinates with random blanking and colour, and a reset in the middle of the run.

// File: rtl/tile_text_pkg.sv
package tile_text_pkg;
  localparam int GLYPH_W   = 8;
  localparam int GLYPH_H   = 16;
  localparam int CODE_W    = 7;
  localparam int COL_BITS  = $clog2(GLYPH_W);
  localparam int ROW_BITS  = $clog2(GLYPH_H);
  localparam int ADDR_W    = CODE_W + ROW_BITS;
  localparam int COLOR_W   = 3;

  localparam logic [CODE_W-1:0] CODE_SOLID   = 7'h7F;
  localparam logic [CODE_W-1:0] CODE_PATTERN = 7'h01;
  localparam logic [CODE_W-1:0] CODE_DIGIT0  = 7'h30;
  localparam logic [CODE_W-1:0] CODE_DIGIT9  = 7'h39;

  // seven-segment mask: bit0 top .. bit6 middle
  function automatic logic [6:0] seg_mask(input logic [3:0] digit);
    case (digit)
      4'd0: seg_mask = 7'h3F;
      4'd1: seg_mask = 7'h06;
      4'd2: seg_mask = 7'h5B;
      4'd3: seg_mask = 7'h4F;
      4'd4: seg_mask = 7'h66;
      4'd5: seg_mask = 7'h6D;
      4'd6: seg_mask = 7'h7D;
      4'd7: seg_mask = 7'h07;
      4'd8: seg_mask = 7'h7F;
      4'd9: seg_mask = 7'h6F;
      default: seg_mask = 7'h00;
    endcase
  endfunction

  function automatic logic [GLYPH_W-1:0] digit_word(input logic [6:0] seg,
                                                    input logic [ROW_BITS-1:0] row);
    logic [GLYPH_W-1:0] w;
    w = '0;
    if (row == 4'd2  && seg[0]) w = w | 8'h7E;
    if (row == 4'd7  && seg[6]) w = w | 8'h7E;
    if (row == 4'd12 && seg[3]) w = w | 8'h7E;
    if (row >= 4'd2 && row <= 4'd7) begin
      if (seg[5]) w = w | 8'h40;
      if (seg[1]) w = w | 8'h02;
    end
    if (row >= 4'd7 && row <= 4'd12) begin
      if (seg[4]) w = w | 8'h40;
      if (seg[2]) w = w | 8'h02;
    end
    return w;
  endfunction

  function automatic logic [GLYPH_W-1:0] glyph_word(input logic [CODE_W-1:0] code,
                                                    input logic [ROW_BITS-1:0] row);
    if (code == CODE_SOLID)
      return '1;
    else if (code == CODE_PATTERN)
      return {row, ~row};
    else if (code >= CODE_DIGIT0 && code <= CODE_DIGIT9)
      return digit_word(seg_mask(code[3:0]), row);
    else
      return '0;
  endfunction

  // leftmost column sits in the most significant bit
  function automatic logic pick_bit(input logic [GLYPH_W-1:0] word,
                                    input logic [COL_BITS-1:0] col);
    return word[~col];
  endfunction
endpackage

// File: rtl/tile_addr_stage.sv
module tile_addr_stage
  import tile_text_pkg::*;
#(
  parameter int X_W = 10,
  parameter int Y_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [X_W-1:0]      pix_x,
  input  logic [Y_W-1:0]      pix_y,
  input  logic                video_on,
  input  logic [CODE_W-1:0]   char_code,
  input  logic [COLOR_W-1:0]  fg_color,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [COL_BITS-1:0] col_q,
  output logic                vid_q,
  output logic [COLOR_W-1:0]  color_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      col_q   <= '0;
      vid_q   <= 1'b0;
      color_q <= '0;
    end else begin
      addr_q  <= {char_code, pix_y[ROW_BITS-1:0]};
      col_q   <= pix_x[COL_BITS-1:0];
      vid_q   <= video_on;
      color_q <= fg_color;
    end
  end
endmodule

// File: rtl/glyph_rom.sv
module glyph_rom
  import tile_text_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [COL_BITS-1:0] col_in,
  input  logic                vid_in,
  input  logic [COLOR_W-1:0]  color_in,
  output logic [GLYPH_W-1:0]  word_q,
  output logic [COL_BITS-1:0] col_q,
  output logic                vid_q,
  output logic [COLOR_W-1:0]  color_q
);
  logic [CODE_W-1:0]   rd_code;
  logic [ROW_BITS-1:0] rd_row;
  assign rd_code = addr[ADDR_W-1:ROW_BITS];
  assign rd_row  = addr[ROW_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      col_q   <= '0;
      vid_q   <= 1'b0;
      color_q <= '0;
    end else begin
      word_q  <= glyph_word(rd_code, rd_row);
      col_q   <= col_in;
      vid_q   <= vid_in;
      color_q <= color_in;
    end
  end

  // R1: blank code reads as empty row
  a_r1_blank_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_code == '0) |=> (word_q == '0));
  // R2: solid code reads as full row
  a_r2_solid_row: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_code == CODE_SOLID) |=> (word_q == '1));
  // R3: test pattern follows the row index
  a_r3_pattern_row: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_code == CODE_PATTERN) |=> (word_q == {$past(rd_row), ~$past(rd_row)}));
endmodule

// File: rtl/bit_pick_stage.sv
module bit_pick_stage
  import tile_text_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [GLYPH_W-1:0]  word,
  input  logic [COL_BITS-1:0] col,
  input  logic                vid_in,
  input  logic [COLOR_W-1:0]  color_in,
  output logic                pix_q,
  output logic                vid_q,
  output logic [COLOR_W-1:0]  color_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q   <= 1'b0;
      vid_q   <= 1'b0;
      color_q <= '0;
    end else begin
      pix_q   <= pick_bit(word, col);
      vid_q   <= vid_in;
      color_q <= color_in;
    end
  end

  // R5: a full row always yields a lit pixel, an empty one a dark pixel
  a_r5_full_word_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (word == '1) |=> pix_q);
  a_r5_empty_word_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (word == '0) |=> !pix_q);
endmodule

// File: rtl/text_tile_renderer.sv
module text_tile_renderer
  import tile_text_pkg::*;
#(
  parameter int X_W = 10,
  parameter int Y_W = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [X_W-1:0]             pix_x,
  input  logic [Y_W-1:0]             pix_y,
  input  logic                       video_on,
  input  logic [CODE_W-1:0]          char_code,
  input  logic [COLOR_W-1:0]         fg_color,
  output logic [X_W-COL_BITS-1:0]    cell_col,
  output logic [Y_W-ROW_BITS-1:0]    cell_row,
  output logic                       pix_bit,
  output logic [COLOR_W-1:0]         rgb
);
  localparam int PIPE_DEPTH = 3;

  logic [ADDR_W-1:0]   s1_addr;
  logic [COL_BITS-1:0] s1_col, s2_col;
  logic                s1_vid, s2_vid, s3_vid;
  logic [COLOR_W-1:0]  s1_color, s2_color, s3_color;
  logic [GLYPH_W-1:0]  s2_word;
  logic                s3_pix;

  assign cell_col = pix_x[X_W-1:COL_BITS];
  assign cell_row = pix_y[Y_W-1:ROW_BITS];

  tile_addr_stage #(.X_W(X_W), .Y_W(Y_W)) addr_i (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .video_on(video_on), .char_code(char_code), .fg_color(fg_color),
    .addr_q(s1_addr), .col_q(s1_col), .vid_q(s1_vid), .color_q(s1_color)
  );

  glyph_rom rom_i (
    .clk(clk), .rst_n(rst_n), .addr(s1_addr), .col_in(s1_col),
    .vid_in(s1_vid), .color_in(s1_color),
    .word_q(s2_word), .col_q(s2_col), .vid_q(s2_vid), .color_q(s2_color)
  );

  bit_pick_stage pick_i (
    .clk(clk), .rst_n(rst_n), .word(s2_word), .col(s2_col),
    .vid_in(s2_vid), .color_in(s2_color),
    .pix_q(s3_pix), .vid_q(s3_vid), .color_q(s3_color)
  );

  assign pix_bit = s3_pix;

  for (genvar ch = 0; ch < COLOR_W; ch++) begin : g_chan
    assign rgb[ch] = s3_pix & s3_color[ch] & s3_vid;
  end

  // edges seen since reset, saturating at the pipeline depth
  logic [1:0] since_rst;
  logic       primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_rst <= '0;
    else if (since_rst != 2'(PIPE_DEPTH))
      since_rst <= since_rst + 2'd1;
  end
  assign primed = (since_rst == 2'(PIPE_DEPTH));

  // R8: blanked input three edges ago gives black
  a_r8_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(video_on, 3)) |-> (rgb == '0));
  // R7: output colour never exceeds the delayed foreground
  a_r7_color_mask: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> ((rgb & ~$past(fg_color, 3)) == '0));
  // R7: a lit visible pixel carries the whole delayed foreground
  a_r7_lit_color: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(video_on, 3) && pix_bit) |-> (rgb == $past(fg_color, 3)));
  // R10: outputs stay dark until the pipeline has refilled
  a_r10_refill_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd0) |-> (!pix_bit && rgb == '0));
endmodule

// File: tb/text_tile_renderer_tb.sv
module text_tile_renderer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] pix_x = '0;
  logic [8:0] pix_y = '0;
  logic       video_on = 1'b0;
  logic [6:0] char_code = '0;
  logic [2:0] fg_color = '0;
  logic [6:0] cell_col;
  logic [4:0] cell_row;
  logic       pix_bit;
  logic [2:0] rgb;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [9:0] x;
    logic [8:0] y;
    logic       v;
    logic [6:0] code;
    logic [2:0] c;
  } sample_t;
  sample_t hist[$];

  always #10 clk = ~clk;

  text_tile_renderer dut_i (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .video_on(video_on), .char_code(char_code), .fg_color(fg_color),
    .cell_col(cell_col), .cell_row(cell_row), .pix_bit(pix_bit), .rgb(rgb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // caller's character map
  function automatic logic [6:0] cell_code(input int col, input int row);
    case ((col + row * 3) % 6)
      0: return 7'(8'h30 + col % 10);
      1: return 7'h01;
      2: return 7'h7F;
      3: return 7'h00;
      4: return 7'h41;
      default: return 7'(8'h30 + (col + row) % 10);
    endcase
  endfunction

  function automatic bit digit_lit(input int d, input int r, input int c);
    int segs [10] = '{'h3F, 'h06, 'h5B, 'h4F, 'h66, 'h6D, 'h7D, 'h07, 'h7F, 'h6F};
    int s = segs[d];
    bit mid = (c >= 1 && c <= 6);
    if (mid && r == 2  && s[0]) return 1;
    if (mid && r == 7  && s[6]) return 1;
    if (mid && r == 12 && s[3]) return 1;
    if (r >= 2 && r <= 7  && ((c == 1 && s[5]) || (c == 6 && s[1]))) return 1;
    if (r >= 7 && r <= 12 && ((c == 1 && s[4]) || (c == 6 && s[2]))) return 1;
    return 0;
  endfunction

  function automatic bit ref_pix(input int code, input int r, input int c);
    if (code == 'h7F) return 1;
    if (code == 'h01) return (c < 4) ? r[3 - c] : !r[7 - c];
    if (code >= 'h30 && code <= 'h39) return digit_lit(code - 'h30, r, c);
    return 0;
  endfunction

  function automatic string req_of(input int code);
    if (code == 'h7F) return "R2";
    if (code == 'h01) return "R3";
    if (code >= 'h30 && code <= 'h39) return "R4";
    return "R1";
  endfunction

  // called at a falling edge: compare, apply next inputs, move one cycle on
  task automatic step(input int x, input int y, input bit v, input int c);
    sample_t s;
    if (hist.size() == 3) begin
      sample_t e = hist.pop_front();
      bit ep = ref_pix(e.code, e.y[3:0], e.x[2:0]);
      logic [2:0] er = (ep && e.v) ? e.c : 3'b0;
      check(pix_bit == ep, {req_of(e.code), " pix (R5 R6)"}, pix_bit, ep);
      check(rgb == er, e.v ? "R7 rgb (R6)" : "R8 rgb", rgb, er);
    end else begin
      check(pix_bit == 1'b0 && rgb == 3'b0, "R10 refill", {pix_bit, rgb}, 0);
    end
    s.x = 10'(x); s.y = 9'(y); s.v = v; s.c = 3'(c);
    s.code = cell_code(x / 8, y / 16);
    pix_x = s.x; pix_y = s.y; video_on = v; fg_color = s.c; char_code = s.code;
    #1;
    check(cell_col == 7'(x / 8) && cell_row == 5'(y / 16), "R9 cell",
          {cell_col, cell_row}, ((x / 8) << 5) | (y / 16));
    hist.push_back(s);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pix_bit == 1'b0 && rgb == 3'b0, "R10 reset", {pix_bit, rgb}, 0);
    rst_n = 1'b1;
    // every line of the first cell row over twenty cells
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 160; x++) step(x, y, 1'b1, (x / 8) % 8);
    // a full bottom line, white
    for (int x = 0; x < 640; x++) step(x, 470, 1'b1, 7);
    // random coordinates, blanking and colour
    for (int i = 0; i < 4000; i++)
      step($urandom_range(639), $urandom_range(479), $urandom_range(3) != 0,
           $urandom_range(7));
    // reset in the middle of a run
    rst_n = 1'b0;
    #2;
    check(pix_bit == 1'b0 && rgb == 3'b0, "R10 async clear", {pix_bit, rgb}, 0);
    hist.delete();
    repeat (3) @(negedge clk);
    check(pix_bit == 1'b0 && rgb == 3'b0, "R10 held", {pix_bit, rgb}, 0);
    rst_n = 1'b1;
    for (int x = 0; x < 200; x++) step(x, 100 + x % 16, 1'b1, 5);
    // blanked line: rgb black while glyph pixels still show
    for (int x = 0; x < 300; x++) step(x, 200 + x % 16, 1'b0, 7);
    for (int i = 0; i < 3; i++) step(0, 0, 1'b1, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule